// File: doc/BRIEF.md
# Quad Command-Programmed Pulse Width Modulator

This block drives four independent pulse outputs. Each channel keeps a latched period value and a latched duty value. Two down counters run from those values: the period counter marks out each cycle, and the duty counter marks out the active part at the start of that cycle. The host programs the block through one write port. A write to address 0 fills a shared 24-bit data register. A write to address 1 delivers an 8-bit command. The command names an operation, a channel and, where the operation needs them, a counter or a polarity.

Each output has its own polarity. After reset an output stays at its inactive level, which is the inverse of its polarity, until the host issues an explicit output-on command. An output that is stopped or switched off also sits at its inactive level. The outputs are registered, so a channel's output follows its counter state one clock later.

Top module: `quad_pwm`

## Requirements
- R1: When reset is released, every output is 0. Reset leaves each channel with polarity active-high, output off, counting stopped, and period and duty values of 0.
- R2: A write with `wr_addr`=0 loads all of `wr_data` into the data register. A write with `wr_addr`=1 is a command and does not change the data register. The command byte `wr_data[7:0]` has these fields: bits [7:4] are the operation code, bits [3:2] the channel, bit 1 the counter select (0 = period, 1 = duty), and bit 0 the polarity argument.
- R3: Operation 0001 copies the data register into the selected channel's period value (select 0) or duty value (select 1). A load made while the channel is counting takes effect at the next period reload.
- R4: Operation 0101 loads both counters from the latched values and starts counting. The first active cycle appears at the output one clock after the command's write edge. The pattern then repeats every max(P,1) clocks, where P is the period value.
- R5: In each period the output is active for the first min(D,P) clocks and inactive for the rest. So D=0 gives a constantly inactive output, and D≥P gives a constantly active one.
- R6: Operation 0010 sets the channel's polarity to the argument bit: 1 makes the active level high, 0 makes it low.
- R7: Until operation 0011 switches a channel's output on, that output holds the inverse of its polarity.
- R8: Operation 0100 switches the output off and returns it to the inactive level.
- R9: Operation 0110 stops counting. A stopped channel's output sits at its inactive level.
- R10: A command changes only the channel named in bits [3:2]. The other channels keep their waveforms.
- R11: Operation codes 0000 and 0111 through 1111 have no effect, whatever the other command bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = data register, 1 = command |
| wr_data | input | CW (24) | Write data; bits [7:0] carry the command |
| pwm_out | output | NCH (4) | Registered channel outputs |

## Verification
The bench sweeps the period and duty values of one channel, with both polarities, across the D=0, D=P and D>P boundaries. It compares every output cycle against the pattern computed from R4 and R5. A counter that reloads one cycle early or late shows up as a wrong period. Using > where ≥ belongs gives the wrong number of active cycles, and an inverted polarity path flips every sample. Window counts over whole periods catch a load that takes effect at the wrong time, or that lands on the wrong channel. They also catch a decoder that acts on unused codes or that captures command bytes into the data register. Off and stopped channels are checked to rest at their inactive level rather than at 0.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [3:0] {
    OP_LOAD    = 4'h1,
    OP_POL     = 4'h2,
    OP_OUT_ON  = 4'h3,
    OP_OUT_OFF = 4'h4,
    OP_RUN     = 4'h5,
    OP_HALT    = 4'h6
  } pwm_op_e;

  localparam int CH_SEL_W = 2;

  typedef struct packed {
    logic [3:0]          op;
    logic [CH_SEL_W-1:0] chan;
    logic                ctr;
    logic                arg;
  } pwm_cmd_t;

endpackage

// File: rtl/pwm_cmd_decode.sv
module pwm_cmd_decode
  import pwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           cmd_wr,
  input  logic [7:0]     cmd_byte,
  output logic [NCH-1:0] ld_per,
  output logic [NCH-1:0] ld_duty,
  output logic [NCH-1:0] set_pol,
  output logic [NCH-1:0] out_on,
  output logic [NCH-1:0] out_off,
  output logic [NCH-1:0] run_go,
  output logic [NCH-1:0] run_halt,
  output logic           pol_val
);

  pwm_cmd_t cmd;
  assign cmd     = pwm_cmd_t'(cmd_byte);
  assign pol_val = cmd.arg;

  always_comb begin
    ld_per   = '0;
    ld_duty  = '0;
    set_pol  = '0;
    out_on   = '0;
    out_off  = '0;
    run_go   = '0;
    run_halt = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cmd_wr && cmd.chan == CH_SEL_W'(i)) begin
        case (cmd.op)
          OP_LOAD: begin
            if (cmd.ctr) ld_duty[i] = 1'b1;
            else         ld_per[i]  = 1'b1;
          end
          OP_POL:     set_pol[i]  = 1'b1;
          OP_OUT_ON:  out_on[i]   = 1'b1;
          OP_OUT_OFF: out_off[i]  = 1'b1;
          OP_RUN:     run_go[i]   = 1'b1;
          OP_HALT:    run_halt[i] = 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_per,
  input  logic          ld_duty,
  input  logic          set_pol,
  input  logic          pol_val,
  input  logic          out_on,
  input  logic          out_off,
  input  logic          run_go,
  input  logic          run_halt,
  input  logic [CW-1:0] load_val,
  output logic          pwm_q,
  output logic          en_q,
  output logic          pol_q,
  output logic          run_q,
  output logic [CW-1:0] per_q
);

  logic [CW-1:0] duty_q;
  logic [CW-1:0] c0_q;
  logic [CW-1:0] c1_q;
  logic          wrap;
  logic          active;

  assign wrap   = (c0_q == '0) || (c0_q == CW'(1));
  assign active = en_q && run_q && (c1_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= '0;
      duty_q <= '0;
      c0_q   <= '0;
      c1_q   <= '0;
      en_q   <= 1'b0;
      pol_q  <= 1'b1;
      run_q  <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      if (ld_per)  per_q  <= load_val;
      if (ld_duty) duty_q <= load_val;
      if (set_pol) pol_q  <= pol_val;

      if (out_on)       en_q <= 1'b1;
      else if (out_off) en_q <= 1'b0;

      if (run_halt) begin
        run_q <= 1'b0;
      end else if (run_go) begin
        run_q <= 1'b1;
        c0_q  <= per_q;
        c1_q  <= duty_q;
      end else if (run_q) begin
        if (wrap) begin
          c0_q <= per_q;
          c1_q <= duty_q;
        end else begin
          c0_q <= c0_q - CW'(1);
          c1_q <= (c1_q != '0) ? c1_q - CW'(1) : '0;
        end
      end

      pwm_q <= active ? pol_q : ~pol_q;
    end
  end

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_out
);

  logic [CW-1:0]          data_q;
  logic [NCH-1:0]         ld_per, ld_duty, set_pol, out_on, out_off, run_go, run_halt;
  logic                   pol_val;
  logic [NCH-1:0]         ch_en, ch_pol, ch_run;
  logic [NCH-1:0][CW-1:0] ch_per;

  always_ff @(posedge clk) begin
    if (rst)                   data_q <= '0;
    else if (wr_en && !wr_addr) data_q <= wr_data;
  end

  pwm_cmd_decode #(.NCH(NCH)) u_dec (
    .cmd_wr   (wr_en && wr_addr),
    .cmd_byte (wr_data[7:0]),
    .ld_per   (ld_per),
    .ld_duty  (ld_duty),
    .set_pol  (set_pol),
    .out_on   (out_on),
    .out_off  (out_off),
    .run_go   (run_go),
    .run_halt (run_halt),
    .pol_val  (pol_val)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .ld_per   (ld_per[g]),
      .ld_duty  (ld_duty[g]),
      .set_pol  (set_pol[g]),
      .pol_val  (pol_val),
      .out_on   (out_on[g]),
      .out_off  (out_off[g]),
      .run_go   (run_go[g]),
      .run_halt (run_halt[g]),
      .load_val (data_q),
      .pwm_q    (pwm_out[g]),
      .en_q     (ch_en[g]),
      .pol_q    (ch_pol[g]),
      .run_q    (ch_run[g]),
      .per_q    (ch_per[g])
    );
  end

endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk #(
  parameter int NCH = 4,
  parameter int CW  = 24
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   wr_addr,
  input logic [7:0]             cmd_b,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0]         pol,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0][CW-1:0] per,
  input logic [CW-1:0]          data_q
);

  logic cmd_wr, op_unused;
  assign cmd_wr    = wr_en && wr_addr;
  assign op_unused = (cmd_b[7:4] == 4'h0) || (cmd_b[7:4] > 4'h6);

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (pwm_out == '0));

  // R11
  unused_op_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && op_unused) |=> ($stable(en) && $stable(pol) && $stable(run) && $stable(per)));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R7
    off_level_chk: assert property (@(posedge clk) disable iff (rst)
      !en[i] |=> (pwm_out[i] == !$past(pol[i])));
    // R9
    stop_level_chk: assert property (@(posedge clk) disable iff (rst)
      !run[i] |=> (pwm_out[i] == !$past(pol[i])));
    // R3
    per_load_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && cmd_b[7:4] == 4'h1 && !cmd_b[1] && cmd_b[3:2] == 2'(i))
        |=> (per[i] == $past(data_q)));
  end

endmodule

bind quad_pwm quad_pwm_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .cmd_b   (wr_data[7:0]),
  .pwm_out (pwm_out),
  .en      (ch_en),
  .pol     (ch_pol),
  .run     (ch_run),
  .per     (ch_per),
  .data_q  (data_q)
);

// File: tb/quad_pwm_test.sv
`timescale 1ns/1ps
module quad_pwm_test;
  localparam int NCH = 4;
  localparam int CW  = 24;
  localparam logic [3:0] LOAD = 4'h1, POL = 4'h2, ON = 4'h3, OFF = 4'h4, RUN = 4'h5, HALT = 4'h6;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wr_addr = 1'b0;
  logic [CW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_pwm #(.NCH(NCH), .CW(CW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] op, input int ch, input bit ctr, input bit arg);
    wr(1'b1, int'({op, 2'(ch), ctr, arg}));
  endtask

  task automatic win(input int ch, input int skip, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < skip; k++) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, hi2, bad, other_bad, first_act, first_exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_out == '0, "R1 reset outputs", int'(pwm_out), 0);

    // R7: active-low polarity, output still off -> held high
    cmd(POL, 0, 0, 0);
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R7 off output at inverse polarity", int'(pwm_out[0]), 1);

    // R4 R5 R6 sweep on channel 0
    other_bad = 0;
    for (int p = 1; p <= 5; p++) begin
      for (int d = 0; d <= 6; d++) begin
        for (int pl = 0; pl < 2; pl++) begin
          cmd(HALT, 0, 0, 0);
          wr(1'b0, p); cmd(LOAD, 0, 0, 0);
          wr(1'b0, d); cmd(LOAD, 0, 1, 0);
          cmd(POL, 0, 0, pl[0]);
          cmd(ON, 0, 0, 0);
          @(negedge clk);
          chk(pwm_out[0] == !pl[0], "R9 stopped channel inactive", int'(pwm_out[0]), int'(!pl[0]));
          cmd(RUN, 0, 0, 0);
          bad = 0; first_act = 0; first_exp = 0;
          for (int n = 0; n < 2 * p; n++) begin
            logic e;
            @(negedge clk);
            e = ((n % p) < d) ? pl[0] : !pl[0];
            if (pwm_out[0] != e) begin
              if (bad == 0) begin first_act = int'(pwm_out[0]); first_exp = int'(e); end
              bad++;
            end
            if (pwm_out[3:1] != 3'b000) other_bad++;
          end
          chk(bad == 0, $sformatf("R4 R5 R6 waveform P=%0d D=%0d pol=%0d", p, d, pl),
              first_act, first_exp);
        end
      end
    end
    chk(other_bad == 0, "R10 idle channels undisturbed by sweep", other_bad, 0);

    // R3: duty change while running takes effect at next reload
    cmd(HALT, 0, 0, 0);
    wr(1'b0, 4); cmd(LOAD, 0, 0, 0);
    wr(1'b0, 1); cmd(LOAD, 0, 1, 0);
    cmd(POL, 0, 0, 1); cmd(ON, 0, 0, 0); cmd(RUN, 0, 0, 0);
    win(0, 0, 8, hi);
    chk(hi == 2, "R3 duty 1 of period 4 over 8 cycles", hi, 2);
    wr(1'b0, 3); cmd(LOAD, 0, 1, 0);
    win(0, 6, 8, hi);
    chk(hi == 6, "R3 reloaded duty 3 of period 4", hi, 6);

    // R11: unused codes with every argument combination
    wr(1'b0, 1);
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || op > 6) begin
        for (int a = 0; a < 4; a++) cmd(4'(op), 0, a[1], a[0]);
      end
    end
    win(0, 0, 8, hi);
    chk(hi == 6, "R11 unused codes ignored", hi, 6);

    // R10: two more channels with different settings
    wr(1'b0, 3); cmd(LOAD, 2, 0, 0);
    wr(1'b0, 1); cmd(LOAD, 2, 1, 0);
    cmd(POL, 2, 0, 0); cmd(ON, 2, 0, 0); cmd(RUN, 2, 0, 0);
    wr(1'b0, 5); cmd(LOAD, 1, 0, 0); cmd(LOAD, 1, 1, 0);
    cmd(POL, 1, 0, 1); cmd(ON, 1, 0, 0); cmd(RUN, 1, 0, 0);
    win(2, 6, 15, hi);
    chk(hi == 10, "R10 R6 channel 2 active-low duty 1 of 3", hi, 10);
    win(1, 0, 15, hi2);
    chk(hi2 == 15, "R10 R5 channel 1 duty equal to period", hi2, 15);
    chk(pwm_out[3] == 1'b0, "R10 channel 3 untouched", int'(pwm_out[3]), 0);

    // R2: command writes leave the data register alone
    wr(1'b0, 1); cmd(LOAD, 3, 1, 0);
    wr(1'b0, 2);
    cmd(POL, 3, 0, 1);
    cmd(LOAD, 3, 0, 0);
    cmd(ON, 3, 0, 0); cmd(RUN, 3, 0, 0);
    win(3, 4, 8, hi);
    chk(hi == 4, "R2 data register kept across command write", hi, 4);

    // R8: output off while counting
    cmd(OFF, 2, 0, 0);
    win(2, 1, 9, hi);
    chk(hi == 9, "R8 off output at inactive level (high)", hi, 9);

    // R9: halt while enabled
    cmd(ON, 2, 0, 0);
    cmd(HALT, 2, 0, 0);
    win(2, 1, 9, hi);
    chk(hi == 9, "R9 halted channel at inactive level", hi, 9);
    win(1, 0, 10, hi2);
    chk(hi2 == 10, "R10 channel 1 unaffected by channel 2 commands", hi2, 10);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule